// File: doc/BRIEF.md
# Sectored Lazy-Fetch Write-Allocate Cache

A small set-associative data cache whose 128-byte lines are split into four 32-byte sectors. Each sector has its own valid and modified flags. Each sector also has a per-byte write mask. A write never fetches from memory. It allocates the line if needed, stores its bytes, sets the matching mask bits and marks the sector valid and modified. Memory is read only when a later read lands on a sector that is not valid, or that is modified with an incomplete mask. Only that one sector is fetched. The returned bytes fill only the holes the mask leaves open.

The CPU side issues 32-bit word reads and writes with byte enables over a valid/ready stream. Reads return one word on a valid/ready response stream. Writes produce no response. While a read response is held (rsp_valid high, rsp_ready low), rsp_data is frozen and no new request is taken. On the memory side, sector-sized requests (read fills or write-backs with a byte mask) use valid/ready. Fill data returns on a valid/ready stream that is ready only while a fill is awaited. One miss is outstanding at most: req_ready stays low from acceptance until the request is finished. Victims are chosen by true LRU within the set. On eviction, only the modified sectors are written back.

Top module: `sector_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R2: A write of any byte-enable pattern, including to a line not present, causes no memory read. Only a write-back of a dirty victim may occur.
- R3: A read of a sector that is valid and fully covered (filled, or every byte written) returns its word with no memory access.
- R4: A read of a sector that is absent, or modified with a partial mask, issues exactly one memory read. In the returned word, bytes written earlier keep the written value and the other bytes take the fill data.
- R5: A fill request (mem_req_write=0) carries the byte address of the sector, {tag, set, sector, 5'b0}. Its address stays stable while mem_req_ready is low.
- R6: On eviction, each modified sector is written back as one memory write (mem_req_write=1). The write carries mem_req_mask with bit b set for each byte b written in that sector, or all ones once the sector has been filled. Unmodified sectors are not written.
- R7: Evicting a line with no modified sector causes no memory write.
- R8: The victim is the least recently used way of the set. Hits and allocations both count as uses.
- R9: req_ready is low while a request is in progress, including while a read response waits.
- R10: While rsp_valid is 1 and rsp_ready is 0, rsp_valid stays 1 and rsp_data stays stable.

Address fields (word address req_addr): word-in-sector [2:0], sector [4:3], set [6:5], tag above. Byte enable bit i selects bits [8i+7:8i] of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | CPU request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Word address |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response consumed |
| rsp_data | output | 32 | Read data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = sector write-back, 0 = sector fill |
| mem_req_addr | output | 16 | Sector byte address |
| mem_req_wdata | output | 256 | Write-back data |
| mem_req_mask | output | 32 | Write-back byte mask |
| mem_fill_valid | input | 1 | Fill data valid |
| mem_fill_ready | output | 1 | Fill awaited |
| mem_fill_data | input | 256 | Fill sector data |

## Verification
The hardest situation to reach is an eviction whose victim holds a sector that is modified but only partly written. Reaching it needs a partial write to one tag, then enough other tags in the same set to make that line the least recently used, then one more miss. The directed sequence writes two bytes under one tag, reads a second tag in the same set, then reads a third tag. The bench then checks the single write-back's address, byte mask and data. A follow-up read of the evicted tag confirms that the written bytes came back from memory and that the clean victim produced no write.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int SECT_BYTES = 32;
  localparam int SECT_BITS  = SECT_BYTES * 8;
  localparam int WORD_BYTES = 4;

  typedef struct packed {
    logic                  valid;
    logic                  dirty;
    logic [SECT_BYTES-1:0] wmask;
  } sect_state_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_EVICT, ST_RDREQ, ST_RDWAIT, ST_RESP
  } ctl_state_t;
endpackage

// File: rtl/sc_tag_match.sv
module sc_tag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 7,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]            way_present,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] eq;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = way_present[w] && (way_tag[w] == tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (eq[w]) hit_way = WAY_W'(w);
  end
  assign hit = |eq;
endmodule

// File: rtl/sc_lru.sv
module sc_lru #(
  parameter int SETS = 4,
  parameter int WAYS = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] query_set,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] age [SETS][WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age[s][w] <= WAY_W'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age[touch_set][w] <= '0;
        else if (age[touch_set][w] < age[touch_set][touch_way])
          age[touch_set][w] <= age[touch_set][w] + WAY_W'(1);
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (age[query_set][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
  end

  for (genvar s = 0; s < SETS; s++) begin : g_chk
    logic [WAYS-1:0] oldest;
    always_comb
      for (int w = 0; w < WAYS; w++)
        oldest[w] = (age[s][w] == WAY_W'(WAYS - 1));
    // R8
    one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest) == 1);
  end
endmodule

// File: rtl/sc_merge.sv
module sc_merge #(
  parameter int NBYTES = 32
) (
  input  logic [NBYTES-1:0]   keep,
  input  logic [NBYTES*8-1:0] old_d,
  input  logic [NBYTES*8-1:0] fill_d,
  output logic [NBYTES*8-1:0] merged
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign merged[b*8 +: 8] = keep[b] ? old_d[b*8 +: 8] : fill_d[b*8 +: 8];
  end
endmodule

// File: rtl/sector_cache.sv
module sector_cache
  import sc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SETS    = 4,
  parameter int WAYS    = 2,
  parameter int SECTORS = 4,
  localparam int WA_W   = ADDR_W - 2,
  localparam int WOFF_W = $clog2(SECT_BYTES / WORD_BYTES),
  localparam int SEC_W  = $clog2(SECTORS),
  localparam int SET_W  = $clog2(SETS),
  localparam int SEC_LO = WOFF_W,
  localparam int SET_LO = SEC_LO + SEC_W,
  localparam int TAG_LO = SET_LO + SET_W,
  localparam int TAG_W  = WA_W - TAG_LO,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SOFF_W = $clog2(SECT_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [WA_W-1:0]       req_addr,
  input  logic [WORD_BYTES-1:0] req_be,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [31:0]           rsp_data,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic                  mem_req_write,
  output logic [ADDR_W-1:0]     mem_req_addr,
  output logic [SECT_BITS-1:0]  mem_req_wdata,
  output logic [SECT_BYTES-1:0] mem_req_mask,
  input  logic                  mem_fill_valid,
  output logic                  mem_fill_ready,
  input  logic [SECT_BITS-1:0]  mem_fill_data
);
  ctl_state_t st;
  logic                  cur_wr;
  logic [WA_W-1:0]       cur_addr;
  logic [WORD_BYTES-1:0] cur_be;
  logic [31:0]           cur_wd;
  logic [WAY_W-1:0]      cur_way;
  logic [SEC_W-1:0]      ev_idx;

  sect_state_t          sst    [SETS][WAYS][SECTORS];
  logic [SECT_BITS-1:0] dat    [SETS][WAYS][SECTORS];
  logic [TAG_W-1:0]     tag_q  [SETS][WAYS];
  logic                 lvld   [SETS][WAYS];

  logic [WOFF_W-1:0] c_woff;
  logic [SEC_W-1:0]  c_sec;
  logic [SET_W-1:0]  c_set;
  logic [TAG_W-1:0]  c_tag;
  assign c_woff = cur_addr[WOFF_W-1:0];
  assign c_sec  = cur_addr[SEC_LO +: SEC_W];
  assign c_set  = cur_addr[SET_LO +: SET_W];
  assign c_tag  = cur_addr[TAG_LO +: TAG_W];

  logic [WAYS-1:0][TAG_W-1:0] way_tags;
  logic [WAYS-1:0]            way_pres;
  always_comb
    for (int w = 0; w < WAYS; w++) begin
      way_tags[w] = tag_q[c_set][w];
      way_pres[w] = lvld[c_set][w];
    end

  logic             hit;
  logic [WAY_W-1:0] hit_way, victim;
  sc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .way_tag(way_tags), .way_present(way_pres), .tag(c_tag),
    .hit(hit), .hit_way(hit_way));

  sc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(st == ST_LOOK && hit),
    .touch_set(c_set), .touch_way(hit_way), .query_set(c_set),
    .victim(victim));

  sect_state_t look_sec, rd_sec, ev_sec;
  assign look_sec = sst[c_set][hit_way][c_sec];
  assign rd_sec   = sst[c_set][cur_way][c_sec];
  assign ev_sec   = sst[c_set][cur_way][ev_idx];

  logic ev_dirty, ev_step, look_full;
  assign ev_dirty  = lvld[c_set][cur_way] && ev_sec.valid && ev_sec.dirty;
  assign ev_step   = (st == ST_EVICT) && (!ev_dirty || mem_req_ready);
  assign look_full = look_sec.valid && (&look_sec.wmask);

  logic [SECT_BYTES-1:0] wr_mask, rd_keep;
  assign wr_mask = SECT_BYTES'(cur_be) << (int'(c_woff) * WORD_BYTES);
  assign rd_keep = rd_sec.valid ? rd_sec.wmask : '0;

  logic [SECT_BITS-1:0] merged;
  sc_merge #(.NBYTES(SECT_BYTES)) u_merge (
    .keep(rd_keep), .old_d(dat[c_set][cur_way][c_sec]),
    .fill_d(mem_fill_data), .merged(merged));

  assign req_ready      = (st == ST_IDLE);
  assign mem_fill_ready = (st == ST_RDWAIT);
  assign mem_req_valid  = (st == ST_RDREQ) || (st == ST_EVICT && ev_dirty);
  assign mem_req_write  = (st == ST_EVICT);
  assign mem_req_addr   = (st == ST_EVICT)
                        ? {tag_q[c_set][cur_way], c_set, ev_idx, SOFF_W'(0)}
                        : {c_tag, c_set, c_sec, SOFF_W'(0)};
  assign mem_req_wdata  = dat[c_set][cur_way][ev_idx];
  assign mem_req_mask   = ev_sec.wmask;

  // Data storage: no reset needed, validity lives in sst.
  always_ff @(posedge clk) begin
    if (st == ST_LOOK && hit && cur_wr) begin
      for (int i = 0; i < WORD_BYTES; i++)
        if (cur_be[i])
          dat[c_set][hit_way][c_sec][(int'(c_woff) * WORD_BYTES + i) * 8 +: 8] <= cur_wd[i*8 +: 8];
    end else if (st == ST_RDWAIT && mem_fill_valid) begin
      dat[c_set][cur_way][c_sec] <= merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_wr    <= 1'b0;
      cur_addr  <= '0;
      cur_be    <= '0;
      cur_wd    <= '0;
      cur_way   <= '0;
      ev_idx    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          lvld[s][w]  <= 1'b0;
          tag_q[s][w] <= '0;
          for (int c = 0; c < SECTORS; c++) sst[s][w][c] <= '0;
        end
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          cur_wr <= req_write; cur_addr <= req_addr;
          cur_be <= req_be;    cur_wd   <= req_wdata;
          st     <= ST_LOOK;
        end
        ST_LOOK: begin
          if (!hit) begin
            cur_way <= victim;
            ev_idx  <= '0;
            st      <= ST_EVICT;
          end else if (cur_wr) begin
            sst[c_set][hit_way][c_sec] <= '{valid: 1'b1, dirty: 1'b1,
              wmask: (look_sec.valid ? look_sec.wmask : '0) | wr_mask};
            st <= ST_IDLE;
          end else if (look_full) begin
            rsp_data  <= dat[c_set][hit_way][c_sec][int'(c_woff) * 32 +: 32];
            rsp_valid <= 1'b1;
            st        <= ST_RESP;
          end else begin
            cur_way <= hit_way;
            st      <= ST_RDREQ;
          end
        end
        ST_EVICT: if (ev_step) begin
          if (ev_idx == SEC_W'(SECTORS - 1)) begin
            tag_q[c_set][cur_way] <= c_tag;
            lvld[c_set][cur_way]  <= 1'b1;
            for (int c = 0; c < SECTORS; c++) sst[c_set][cur_way][c] <= '0;
            st <= ST_LOOK;
          end else begin
            ev_idx <= ev_idx + SEC_W'(1);
          end
        end
        ST_RDREQ: if (mem_req_ready) st <= ST_RDWAIT;
        ST_RDWAIT: if (mem_fill_valid) begin
          sst[c_set][cur_way][c_sec] <= '{valid: 1'b1,
            dirty: rd_sec.valid && rd_sec.dirty, wmask: '1};
          rsp_data  <= merged[int'(c_woff) * 32 +: 32];
          rsp_valid <= 1'b1;
          st        <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) begin
          rsp_valid <= 1'b0;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R6
  wb_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_mask != '0);
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R9
  busy_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R3
  clean_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOOK) && hit && look_sec.valid && !look_sec.dirty |-> &look_sec.wmask);
endmodule

// File: tb/sector_cache_test.sv
`timescale 1ns/1ps
module sector_cache_test;
  logic         clk = 0, rst_n = 0;
  logic         req_valid = 0, req_write = 0;
  logic         req_ready;
  logic [13:0]  req_addr = '0;
  logic [3:0]   req_be = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid, rsp_ready = 0;
  logic [31:0]  rsp_data;
  logic         mem_req_valid, mem_req_write, mem_fill_ready;
  logic         mem_req_ready = 1;
  logic [15:0]  mem_req_addr;
  logic [255:0] mem_req_wdata, mem_fill_data = '0;
  logic [31:0]  mem_req_mask;
  logic         mem_fill_valid = 0;

  sector_cache uut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, rd_cnt = 0, wb_cnt = 0, fill_cnt = 0;
  logic [15:0]  last_rd_addr, last_wb_addr, pend_addr;
  logic [31:0]  last_wb_mask;
  logic [255:0] last_wb_data;
  logic [7:0]   memb [int];
  logic [7:0]   refb [int];
  bit           done = 0;

  function automatic logic [7:0] pat(int a);
    return 8'(a * 7 + (a >> 8) * 13 + 1);
  endfunction

  function automatic logic [31:0] exp_word(int a);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[i*8 +: 8] = refb.exists(a + i) ? refb[a + i] : pat(a + i);
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: always ready, fill returns three cycles after the request
  initial forever begin
    @(negedge clk);
    if (mem_fill_valid) mem_fill_valid = 0;
    if (fill_cnt > 0) begin
      fill_cnt--;
      if (fill_cnt == 0) begin
        for (int b = 0; b < 32; b++)
          mem_fill_data[b*8 +: 8] = memb.exists(int'(pend_addr) + b)
                                  ? memb[int'(pend_addr) + b] : pat(int'(pend_addr) + b);
        mem_fill_valid = 1;
      end
    end
    if (mem_req_valid) begin
      if (mem_req_write) begin
        wb_cnt++;
        last_wb_addr = mem_req_addr; last_wb_mask = mem_req_mask;
        last_wb_data = mem_req_wdata;
        for (int b = 0; b < 32; b++)
          if (mem_req_mask[b]) memb[int'(mem_req_addr) + b] = mem_req_wdata[b*8 +: 8];
      end else begin
        rd_cnt++;
        last_rd_addr = mem_req_addr;
        pend_addr = mem_req_addr;
        fill_cnt = 3;
      end
    end
  end

  task automatic issue(bit wr, int a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = 14'(a >> 2); req_be = be; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_write(int a, logic [3:0] be, logic [31:0] d);
    issue(1, a, be, d);
    for (int i = 0; i < 4; i++) if (be[i]) refb[a + i] = d[i*8 +: 8];
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_read(int a, output logic [31:0] d);
    issue(0, a, 4'h0, '0);
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic t_reset();
    chk(req_ready === 1'b1, "R1 req_ready", req_ready, 1);
    chk(rsp_valid === 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(mem_req_valid === 1'b0, "R1 mem_req_valid", mem_req_valid, 0);
  endtask

  task automatic t_lazy_write();
    logic [31:0] d; int r0;
    r0 = rd_cnt;
    do_write(16'h0208, 4'b0010, 32'h0000AB00);
    chk(rd_cnt == r0, "R2 no read on partial write", rd_cnt, r0);
    issue(0, 16'h0208, 4'h0, '0);
    chk(req_ready === 1'b0, "R9 busy during miss", req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    d = rsp_data; rsp_ready = 1; @(negedge clk); rsp_ready = 0;
    chk(rd_cnt == r0 + 1, "R4 one fill for partial sector", rd_cnt, r0 + 1);
    chk(last_rd_addr == 16'h0200, "R5 fill sector address", last_rd_addr, 16'h0200);
    chk(d == exp_word(16'h0208), "R4 merged word", d, exp_word(16'h0208));
    do_read(16'h020C, d);
    chk(rd_cnt == r0 + 1, "R3 filled sector no refetch", rd_cnt, r0 + 1);
    chk(d == exp_word(16'h020C), "R3 data after fill", d, exp_word(16'h020C));
  endtask

  task automatic t_full_sector();
    logic [31:0] d; int r0;
    r0 = rd_cnt;
    for (int w = 0; w < 8; w++) do_write(16'h0260 + w * 4, 4'hF, 32'hC0DE0000 + w);
    do_read(16'h0274, d);
    chk(rd_cnt == r0, "R3 fully written sector no read", rd_cnt, r0);
    chk(d == 32'hC0DE0005, "R3 fully written data", d, 32'hC0DE0005);
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    issue(0, 16'h0268, 4'h0, '0);
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b1 && rsp_data == held, "R10 response held", rsp_data, held);
    chk(req_ready === 1'b0, "R9 no accept while response waits", req_ready, 0);
    chk(held == 32'hC0DE0002, "R10 response data", held, 32'hC0DE0002);
    rsp_ready = 1; @(negedge clk); rsp_ready = 0;
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R9 released", rsp_valid, 0);
  endtask

  task automatic t_evict();
    logic [31:0] d; int w0;
    do_write(16'h04C0, 4'b0011, 32'h00001234);
    do_read(16'h0680, d);
    w0 = wb_cnt;
    do_read(16'h0880, d);
    chk(wb_cnt == w0 + 1, "R6 one write-back", wb_cnt, w0 + 1);
    chk(last_wb_addr == 16'h04C0, "R8 LRU victim address", last_wb_addr, 16'h04C0);
    chk(last_wb_mask == 32'h3, "R6 write-back mask", last_wb_mask, 32'h3);
    chk(last_wb_data[15:0] == 16'h1234, "R6 write-back data", last_wb_data[15:0], 16'h1234);
    chk(d == exp_word(16'h0880), "R4 miss data", d, exp_word(16'h0880));
    w0 = wb_cnt;
    do_read(16'h04C0, d);
    chk(wb_cnt == w0, "R7 clean victim no write", wb_cnt, w0);
    chk(d == exp_word(16'h04C0), "R6 written bytes return", d, exp_word(16'h04C0));
  endtask

  task automatic t_lru();
    logic [31:0] d; int r0;
    do_read(16'h0300, d);
    do_read(16'h0500, d);
    do_read(16'h0300, d);
    do_read(16'h0700, d);
    r0 = rd_cnt;
    do_read(16'h0300, d);
    chk(rd_cnt == r0, "R8 recently hit way kept", rd_cnt, r0);
    do_read(16'h0500, d);
    chk(rd_cnt == r0 + 1, "R8 LRU way evicted", rd_cnt, r0 + 1);
    chk(d == exp_word(16'h0500), "R8 refetched data", d, exp_word(16'h0500));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_lazy_write();
    t_full_sector();
    t_backpressure();
    t_evict();
    t_lru();
    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule